// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes an eight-bit word between two ports, A and B, in either direction, without inverting it. Each direction owns a bank of level-sensitive latches, so a word can be parked in one direction while the other direction carries or stores something else. Every direction is steered by three active-low inputs: a chip enable, a latch enable and an output enable.

A direction's latches follow their input port only while both its chip enable and its latch enable are low. They freeze the word that was present when either of those inputs goes high. A direction drives its output port only while both its chip enable and its output enable are low. The word it drives is always the current latch content.

Each port is split into a data input, a data output and an output-valid flag. A surrounding pad ring or tri-state wrapper turns the flag into a high-impedance condition. An active-low asynchronous reset clears both latch banks.

Top module: `latched_xcvr`

## Requirements
- R1: While rst_n is low, both latch banks hold zero, so b_o and a_o read 8'h00 whatever the data inputs and latch enables do. After rst_n rises, the banks keep zero until a latch is opened.
- R2: With ce_ab_n and le_ab_n both low, the A-to-B latch is transparent and b_o equals a_i.
- R3: A rising edge on le_ab_n while ce_ab_n is low stores the a_i value present before the edge. Later changes on a_i do not reach b_o.
- R4: While ce_ab_n is high, the A-to-B latch keeps its content whatever le_ab_n and a_i do. A rising edge of ce_ab_n while the latch is transparent stores the word present at that moment.
- R5: b_oe is 1 exactly when ce_ab_n and oe_ab_n are both low; otherwise port B is high impedance (b_oe is 0).
- R6: b_o always equals the A-to-B latch content, bit for bit, with no inversion.
- R7: oe_ab_n never changes what the A-to-B latch stores, and le_ab_n never changes b_oe.
- R8: The B-to-A direction behaves in the same way from b_i to a_o and a_oe, under ce_ba_n, le_ba_n and oe_ba_n. It runs independently of the A-to-B controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, clears both latch banks |
| ce_ab_n | input | 1 | A-to-B chip enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low (low = transparent) |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| ce_ba_n | input | 1 | B-to-A chip enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low (low = transparent) |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_i | input | W | Data arriving on port A |
| a_o | output | W | B-to-A latch content presented on port A |
| a_oe | output | 1 | Port A driven when 1, high impedance when 0 |
| b_i | input | W | Data arriving on port B |
| b_o | output | W | A-to-B latch content presented on port B |
| b_oe | output | 1 | Port B driven when 1, high impedance when 0 |

## Verification
The data words alternate between complementary bit patterns (A5/5A, 3C/C3, 81/7E) and all-ones/all-zeros. A stuck, swapped or inverted bit therefore shows up, as does a copy taken from the wrong port.

The control sequences check each enable apart from the others:
- The latch enable is closed and the input is then changed. This separates a held word from a transparent path.
- The chip enable is raised while the latch enable stays low. This shows that the chip enable alone freezes the latch.
- The output enable is toggled around a latch update. This shows that it gates only driving.
- One direction is held closed while the other stays open. This exposes any cross-coupling between the two banks.

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         ce_ab_n,
  input  logic         le_ab_n,
  input  logic         oe_ab_n,
  input  logic         ce_ba_n,
  input  logic         le_ba_n,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe
);

  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;

  always_latch begin
    if (!rst_n)                    ab_q <= '0;
    else if (!ce_ab_n && !le_ab_n) ab_q <= a_i;
  end

  always_latch begin
    if (!rst_n)                    ba_q <= '0;
    else if (!ce_ba_n && !le_ba_n) ba_q <= b_i;
  end

  assign b_o  = ab_q;
  assign a_o  = ba_q;
  assign b_oe = !ce_ab_n && !oe_ab_n;
  assign a_oe = !ce_ba_n && !oe_ba_n;

  // R3: closing the latch enable keeps the word that was flowing through
  a_r3_capture_ab: assert property (@(posedge le_ab_n) disable iff (!rst_n)
    !ce_ab_n |-> (b_o == a_i));

  // R8: same capture rule in the B-to-A direction
  a_r8_capture_ba: assert property (@(posedge le_ba_n) disable iff (!rst_n)
    !ce_ba_n |-> (a_o == b_i));

  // R4: raising the chip enable over an open latch freezes the live word
  a_r4_ce_close: assert property (@(posedge ce_ab_n) disable iff (!rst_n)
    !le_ab_n |-> (b_o == a_i));

  // R5: port B was not driven just before its output enable is asserted
  a_r5_enable_edge: assert property (@(negedge oe_ab_n) disable iff (!rst_n)
    1'b1 |-> !b_oe);

endmodule

// File: tb/latched_xcvr_bench.sv
module latched_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic ce_ab_n = 1'b1, le_ab_n = 1'b1, oe_ab_n = 1'b1;
  logic ce_ba_n = 1'b1, le_ba_n = 1'b1, oe_ba_n = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic a_oe, b_oe;

  latched_xcvr #(.W(W)) u_latched_xcvr (
    .rst_n(rst_n), .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .a_i(a_i), .a_o(a_o), .a_oe(a_oe), .b_i(b_i), .b_o(b_o), .b_oe(b_oe)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int m_ab = 0;
  int m_ba = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cab, lab, oab, cba, lba, oba,
                      input logic [W-1:0] a, b, input string tag);
    @(negedge clk);
    ce_ab_n = cab; le_ab_n = lab; oe_ab_n = oab;
    ce_ba_n = cba; le_ba_n = lba; oe_ba_n = oba;
    a_i = a; b_i = b;
    if (!rst_n) begin
      m_ab = 0;
      m_ba = 0;
    end else begin
      if (!cab && !lab) m_ab = int'(a);
      if (!cba && !lba) m_ba = int'(b);
    end
    @(posedge clk);
    check({tag, " b_o"},  int'(b_o),  m_ab);
    check({tag, " b_oe"}, int'(b_oe), (!cab && !oab) ? 1 : 0);
    check({tag, " a_o"},  int'(a_o),  m_ba);
    check({tag, " a_oe"}, int'(a_oe), (!cba && !oba) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset clears both banks even with latches open
    step(0,0,0,0,0,0, 8'hA5, 8'h3C, "R1 reset");
    rst_n = 1'b1;
    step(0,0,0,0,0,0, 8'hA5, 8'h3C, "R2 R5 R8 open");
    step(0,0,0,0,0,0, 8'h5A, 8'hC3, "R2 R6 R8 follow");
    step(0,1,0,0,0,0, 8'h5A, 8'hC3, "R3 close");
    step(0,1,0,0,0,0, 8'hFF, 8'h81, "R3 R8 hold vs open");
    step(0,1,1,0,0,0, 8'hFF, 8'h81, "R5 R7 oe off");
    step(0,0,1,0,0,0, 8'hFF, 8'h81, "R7 latch under oe off");
    step(0,0,0,0,0,0, 8'hFF, 8'h81, "R6 R7 oe back");
    step(1,0,0,0,0,0, 8'hFF, 8'h81, "R4 R5 ce close");
    step(1,0,0,0,0,0, 8'h00, 8'h81, "R4 ce hold");
    step(1,1,0,0,0,0, 8'h11, 8'h81, "R4 le toggle");
    step(1,0,0,0,0,0, 8'h22, 8'h81, "R4 le toggle");
    step(0,0,0,0,0,0, 8'h22, 8'h81, "R2 reopen");
    step(0,0,0,0,1,0, 8'h22, 8'h81, "R8 ba close");
    step(0,0,0,0,1,0, 8'h22, 8'h7E, "R8 ba hold");
    step(0,0,0,1,1,0, 8'h22, 8'h7E, "R8 R5 ba ce off");
    step(0,0,0,0,0,1, 8'h22, 8'h7E, "R8 R7 ba latch no drive");
    step(0,0,0,0,0,0, 8'h22, 8'h7E, "R8 R6 ba drive");
    rst_n = 1'b0;
    step(0,0,0,0,0,0, 8'h00, 8'h00, "R1 mid reset");
    rst_n = 1'b1;
    step(0,1,0,0,1,0, 8'hFF, 8'hFF, "R1 zero after reset");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule